// File: doc/BRIEF.md
# MDIO Management Controller

This block runs single clause-22 management transactions on a two-wire MDC/MDIO bus towards an external PHY. Software writes a control register once to choose the MDC divisor and whether the 32-bit preamble is sent. It then issues one read or one write at a time by writing a command word. For a write, the 16-bit value is placed in the data register first. For a read, the data register holds the value returned by the PHY once the busy flag in the status register has dropped.

The controller derives MDC from the system clock. It shifts the frame out most significant bit first: the preamble (unless suppressed), the start pattern, the opcode, the PHY address, the register address, the turnaround and 16 data bits. During a read it releases MDIO from the turnaround onwards and samples it on each rising MDC edge. A self-clearing reset bit in the control register aborts any transaction and restores the defaults.

Register select on `reg_addr`: 0 command, 1 data, 2 status, 3 control. Reads are combinational.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the status reads 0, the data register reads 0, the command register reads 0, MDC and the MDIO output enable are low, and control reads 0x4E00, which is a divisor field of 39 and no suppression.
- R2: A command write (address 0) with bit 15 (read) or bit 14 (write) set raises busy (status bit 0) on the next cycle. Busy then stays high for exactly N×D cycles, where N is 64 bits (32 with suppression) and D is the MDC period. A command word with neither bit set starts nothing. If both bits are set, bit 15 wins.
- R3: A write frame is sent MSB first with MDIO changing while MDC is low. Its bits are 32 ones of preamble, start 01, opcode 01, the 5-bit PHY address, the 5-bit register, turnaround 10, then the 16 bits held in the data register.
- R4: A read frame uses opcode 10. The output enable is high only for the preamble and the first 14 bits after it, and low for the turnaround and data. The 16 data bits are sampled on the MDC rising edges, MSB first, and are readable from the data register after busy clears.
- R5: The control field in bits 15:9 holds the divisor minus one, so D = field + 1. A field of 0 gives D = 2. In each bit period MDC is low for the first floor(D/2) cycles and high for the rest, and it is low while idle.
- R6: With control bit 8 set, the preamble is skipped and the frame starts with the start pattern, so N = 32.
- R7: While busy is high, command writes and data register writes are ignored. This includes a command written in the final cycle of a transaction. A command in the following cycle is accepted.
- R8: Writing control with bit 0 set clears busy and the data register and restores control to 0x4E00. Bit 0 then reads 1 for 4 cycles and 0 afterwards. All register writes in that window are ignored.
- R9: The PHY address is taken from command bits 9:5 and the register number from bits 4:0. Bits 13:10 have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable; low means released |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Two things can fall in the same clock edge: the end of a running transaction and the arrival of a new command word. The bench waits until its own model reports that the next edge is the final bit edge, and writes a read command into exactly that edge. It then checks that status reads idle afterwards and that a command written on the following cycle starts a new frame. A second overlap, a self-reset landing in the middle of a frame, is judged by the immediate drop of busy and MDC and by the window in which further writes are refused.

// File: rtl/mdio_ctrl.sv
module mdio_ctrl #(
  parameter int RST_CYCLES  = 4,
  parameter int DIV_DEFAULT = 39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DIV_W = 7;
  localparam int CW    = DIV_W + 1;
  localparam int RST_W = $clog2(RST_CYCLES + 1);
  localparam logic [1:0] A_CMD = 2'd0, A_DATA = 2'd1, A_STAT = 2'd2, A_CTRL = 2'd3;

  logic [DIV_W-1:0] div_q;
  logic             sup_q, busy_q, rd_q;
  logic [15:0]      data_q;
  logic [63:0]      frame_q;
  logic [6:0]       left_q;
  logic [CW-1:0]    cnt_q, per_q;
  logic [RST_W-1:0] rst_cnt_q;

  wire          resetting = (rst_cnt_q != '0);
  wire          wr_ok     = reg_we && !resetting;
  wire          sreset    = wr_ok && reg_addr == A_CTRL && reg_wdata[0];
  wire          start     = wr_ok && reg_addr == A_CMD && !busy_q && (reg_wdata[15] || reg_wdata[14]);
  wire          is_rd     = reg_wdata[15];
  wire [CW-1:0] half      = per_q >> 1;
  wire          bit_last  = (cnt_q == per_q - 1'b1);
  wire          rise      = (cnt_q == half - 1'b1);
  wire [CW-1:0] per_nxt   = (div_q == '0) ? CW'(2) : ({1'b0, div_q} + 1'b1);

  wire [31:0] payload = {2'b01, is_rd ? 2'b10 : 2'b01, reg_wdata[9:5], reg_wdata[4:0],
                         is_rd ? 2'b00 : 2'b10, is_rd ? 16'h0000 : data_q};

  assign mdc     = busy_q && (cnt_q >= half);
  assign mdio_o  = frame_q[63];
  assign mdio_oe = busy_q && (!rd_q || left_q > 7'd18);

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = data_q;
      A_STAT:  reg_rdata = {15'h0000, busy_q};
      A_CTRL:  reg_rdata = {div_q, sup_q, 7'h00, resetting};
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_DEFAULT); sup_q <= 1'b0; busy_q <= 1'b0; rd_q <= 1'b0;
      data_q <= '0; frame_q <= '0; left_q <= '0; cnt_q <= '0; per_q <= CW'(2);
      rst_cnt_q <= '0;
    end else if (sreset) begin
      rst_cnt_q <= RST_W'(RST_CYCLES);
      div_q <= DIV_W'(DIV_DEFAULT); sup_q <= 1'b0; busy_q <= 1'b0;
      data_q <= '0; frame_q <= '0; left_q <= '0; cnt_q <= '0;
    end else begin
      if (resetting) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (busy_q) begin
        if (rise && rd_q && left_q <= 7'd16) data_q <= {data_q[14:0], mdio_i};
        if (bit_last) begin
          cnt_q   <= '0;
          left_q  <= left_q - 1'b1;
          frame_q <= frame_q << 1;
          if (left_q == 7'd1) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_ok && reg_addr == A_CTRL) begin
        div_q <= reg_wdata[15:9];
        sup_q <= reg_wdata[8];
      end
      if (wr_ok && reg_addr == A_DATA && !busy_q) data_q <= reg_wdata;
      if (start) begin
        busy_q  <= 1'b1;
        rd_q    <= is_rd;
        cnt_q   <= '0;
        per_q   <= per_nxt;
        left_q  <= sup_q ? 7'd32 : 7'd64;
        frame_q <= sup_q ? {payload, 32'h0000_0000} : {32'hFFFF_FFFF, payload};
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk #(
  parameter int RST_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             wbit0,
  input logic             mdc,
  input logic             mdio_oe,
  input logic             busy_q,
  input logic [6:0]       left_q,
  input logic [RST_W-1:0] rst_cnt_q
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(reg_we && reg_addr == 2'd0));

  // R7
  cmd_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we && reg_addr == 2'd0) |=> (left_q <= $past(left_q)));

  // R5
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);

  // R8
  selfreset_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && wbit0 && rst_cnt_q == '0) |=> (rst_cnt_q != '0 && !busy_q));

  // R8
  selfreset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cnt_q != '0) |=> !$rose(busy_q));
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.RST_W(RST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
  .mdc(mdc), .mdio_oe(mdio_oe), .busy_q(busy_q), .left_q(left_q), .rst_cnt_q(rst_cnt_q)
);

// File: tb/test_mdio_ctrl.sv
module test_mdio_ctrl;
  localparam int CLK_NS = 10;
  localparam int RSTC   = 4;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, mdio_i = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  wire  [15:0] reg_rdata;
  wire mdc, mdio_o, mdio_oe;

  mdio_ctrl i_mdio_ctrl (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_NS/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] payload(bit rdop, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    return {2'b01, rdop ? 2'b10 : 2'b01, phy, rg, rdop ? 2'b00 : 2'b10, rdop ? 16'h0 : wd};
  endfunction

  // behavioural reference model
  bit m_busy = 0, m_rd = 0, m_sup = 0, b0;
  int m_cnt = 0, m_left = 0, m_N = 64, m_D = 2, m_rst = 0, rs0;
  logic [6:0]  m_div = 7'd39;
  logic [15:0] m_data = 16'h0, reply = 16'h0;
  logic [63:0] m_word = 64'h0;
  logic [31:0] m_p;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_left = 0; m_rst = 0; m_div = 7'd39; m_sup = 0; m_data = 16'h0;
    end else begin
      b0 = m_busy; rs0 = m_rst;
      if (reg_we && reg_addr == 2'd3 && reg_wdata[0] && rs0 == 0) begin
        m_rst = RSTC; m_busy = 0; m_div = 7'd39; m_sup = 0; m_data = 16'h0; m_cnt = 0; m_left = 0;
      end else begin
        if (rs0 > 0) m_rst--;
        if (b0) begin
          if (m_rd && m_left <= 16 && m_cnt == m_D/2 - 1) m_data = {m_data[14:0], mdio_i};
          if (m_cnt == m_D - 1) begin
            m_cnt = 0; m_left--;
            if (m_left == 0) m_busy = 0;
          end else m_cnt++;
        end
        if (reg_we && rs0 == 0) begin
          if (reg_addr == 2'd3) begin m_div = reg_wdata[15:9]; m_sup = reg_wdata[8]; end
          else if (reg_addr == 2'd1 && !b0) m_data = reg_wdata;
          else if (reg_addr == 2'd0 && !b0 && (reg_wdata[15] || reg_wdata[14])) begin
            m_rd   = reg_wdata[15];
            m_p    = payload(m_rd, reg_wdata[9:5], reg_wdata[4:0], m_data);
            m_word = m_sup ? {m_p, 32'h0} : {32'hFFFF_FFFF, m_p};
            m_left = m_sup ? 32 : 64; m_N = m_left;
            m_D    = (m_div == 0) ? 2 : int'(m_div) + 1;
            m_cnt  = 0; m_busy = 1;
          end
        end
      end
    end
  end

  bit cap[$];
  logic prev_mdc = 1'b0;
  bit e_mdc, e_oe;

  always @(negedge clk) begin
    if (rst_n) begin
      e_mdc = m_busy && (m_cnt >= m_D/2);
      e_oe  = m_busy && (!m_rd || m_left > 18);
      if (e_oe)
        check("R3 R5 per-cycle mdc/oe/mdio", {mdc, mdio_oe, mdio_o},
              {e_mdc, e_oe, m_word[63-(m_N-m_left)]});
      else
        check("R4 R5 per-cycle mdc/oe", {mdc, mdio_oe}, {e_mdc, 1'b0});
      if (mdc && !prev_mdc && mdio_oe) cap.push_back(mdio_o);
    end
    prev_mdc = mdc;
    mdio_i = (m_busy && m_rd && m_left <= 16 && m_left > 0) ? reply[m_left-1] : 1'b1;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run(output int cyc, output int hi);
    logic [15:0] v;
    cyc = 0; hi = 0;
    forever begin
      rd(2'd2, v);
      if (!v[0]) break;
      cyc++;
      if (mdc) hi++;
      @(negedge clk);
    end
  endtask

  task automatic chk_frame(input string tag, input bit rdop, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd, input bit sup);
    logic [31:0] p;
    logic [63:0] w, act, exp;
    int n, k;
    p = payload(rdop, phy, rg, wd);
    w = sup ? {p, 32'h0} : {32'hFFFF_FFFF, p};
    n = sup ? 32 : 64; act = '0; exp = '0; k = 0;
    for (int i = 0; i < n; i++)
      if (!rdop || (n - i) > 18) begin exp[63-k] = w[63-i]; k++; end
    check({tag, " bit count"}, 64'(cap.size()), 64'(k));
    for (int i = 0; i < cap.size() && i < 64; i++) act[63-i] = cap[i];
    check(tag, act, exp);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cyc, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd2, v); check("R1 status", v, 16'h0000);
    rd(2'd1, v); check("R1 data", v, 16'h0000);
    rd(2'd0, v); check("R1 command", v, 16'h0000);
    rd(2'd3, v); check("R1 control", v, 16'h4E00);
    check("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);
    @(negedge clk);

    // R3 full write frame, R7 writes while busy ignored
    wr(2'd3, 16'h0600);
    rd(2'd3, v); check("R5 control readback", v, 16'h0600);
    wr(2'd1, 16'hA5C3);
    cap.delete();
    wr(2'd0, 16'h4226);
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h1234);
    run(cyc, hi);
    check("R2 busy length D=4 N=64", 64'(cyc + 2), 64'd256);
    rd(2'd1, v); check("R7 data write while busy ignored", v, 16'hA5C3);
    chk_frame("R3 write frame", 1'b0, 5'h11, 5'h06, 16'hA5C3, 1'b0);

    // R6 suppressed preamble, R4 read
    wr(2'd3, 16'h0700);
    reply = 16'hBEEF;
    cap.delete();
    wr(2'd0, 16'h80BF);
    run(cyc, hi);
    check("R6 busy length N=32", 64'(cyc), 64'd128);
    rd(2'd1, v); check("R4 read data", v, 16'hBEEF);
    chk_frame("R4 R6 read frame", 1'b1, 5'h05, 5'h1F, 16'h0, 1'b1);

    // R9 address masking
    wr(2'd3, 16'h0600);
    wr(2'd1, 16'h0F0F);
    cap.delete();
    wr(2'd0, 16'h7D55);
    run(cyc, hi);
    check("R9 busy length", 64'(cyc), 64'd256);
    chk_frame("R9 masked frame", 1'b0, 5'h0A, 5'h15, 16'h0F0F, 1'b0);

    // R2 command without opcode bits
    wr(2'd0, 16'h3FFF);
    rd(2'd2, v); check("R2 no-op command", v, 16'h0000);

    // R5 divisor field 0 and odd divisor
    wr(2'd3, 16'h0100);
    wr(2'd0, 16'h4001);
    run(cyc, hi);
    check("R5 D=2 busy length", 64'(cyc), 64'd64);
    check("R5 D=2 mdc high cycles", 64'(hi), 64'd32);
    wr(2'd3, 16'h0800);
    wr(2'd0, 16'h4003);
    run(cyc, hi);
    check("R5 D=5 busy length", 64'(cyc), 64'd320);
    check("R5 D=5 mdc high cycles", 64'(hi), 64'd192);

    // R7 command landing on the final edge
    wr(2'd3, 16'h0300);
    wr(2'd0, 16'h4002);
    while (!(m_busy && m_left == 1 && m_cnt == m_D - 1)) @(negedge clk);
    wr(2'd0, 16'h8001);
    rd(2'd2, v); check("R7 command on last cycle ignored", v, 16'h0000);
    wr(2'd0, 16'h8001);
    rd(2'd2, v); check("R7 command next cycle accepted", v, 16'h0001);
    run(cyc, hi);

    // R8 self-reset mid transaction
    wr(2'd3, 16'h0600);
    wr(2'd1, 16'h7777);
    wr(2'd0, 16'h4001);
    repeat (10) @(negedge clk);
    wr(2'd3, 16'h1E01);
    rd(2'd2, v); check("R8 busy cleared", v, 16'h0000);
    check("R8 mdc low", mdc, 1'b0);
    rd(2'd3, v); check("R8 reset bit high", v, 16'h4E01);
    wr(2'd0, 16'h4001);
    rd(2'd2, v); check("R8 command ignored in reset", v, 16'h0000);
    wr(2'd3, 16'h0600);
    rd(2'd3, v); check("R8 control write ignored", v, 16'h4E01);
    @(negedge clk);
    rd(2'd3, v); check("R8 reset bit last cycle", v, 16'h4E01);
    @(negedge clk);
    rd(2'd3, v); check("R8 reset bit cleared", v, 16'h4E00);
    rd(2'd1, v); check("R8 data cleared", v, 16'h0000);

    // R5 R4 divisor 40 read
    wr(2'd3, 16'h4F00);
    reply = 16'h8421;
    wr(2'd0, 16'h83E0);
    run(cyc, hi);
    check("R5 D=40 busy length", 64'(cyc), 64'd1280);
    check("R5 D=40 mdc high cycles", 64'(hi), 64'd640);
    rd(2'd1, v); check("R4 read data D=40", v, 16'h8421);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule